// File: doc/BRIEF.md
# BCH8 Remainder-to-Code Byte Packer

This block sits behind a BCH8 encoder that has latched four 32-bit remainder words for each of up to eight sectors. On a start pulse it walks those words through a read port into a register file. It emits the 13-byte check code of every sector as a byte stream with valid, ready and last flags. Each emitted byte is XORed with a fixed constant. The constants are chosen so that a sector whose data is all 0xFF gets a check code that is also all 0xFF, which makes an erased page look self-consistent.

A 3-bit field taken at start gives the sector count minus one. Sectors go out in ascending order. When the final byte of the final sector has been accepted, the block pulses a signal that clears the encoder's enable bit, so the encoder captures no further results.

Top module: `bch8_ecc_packer`

## Requirements
- R1: After reset, out_valid, out_last and eng_clear are low.
- R2: A start pulse accepted while idle produces exactly 13*(sect_cnt_m1+1) output bytes, covering 1 to 8 sectors. out_valid rises in the cycle after the start edge.
- R3: The read address is sector*4 + word, where word 0 to 3 selects a remainder word. Within a sector, byte 0 comes from word 3 bits [7:0]. Bytes 1 to 4 come from word 2, bytes 5 to 8 from word 1 and bytes 9 to 12 from word 0, each word taken most significant byte first.
- R4: Byte k of a sector (k = 0..12) is XORed with the k-th entry of EF 51 2E 09 ED 93 9A C2 97 79 E5 24 B5 (hex).
- R5: When every remainder word equals the bitwise complement of its masked bytes, with the unused word-3 bits at any value, every output byte is 0xFF.
- R6: Sectors are emitted in ascending index order, from 0 to sect_cnt_m1.
- R7: One byte is transferred on each clock edge where out_valid and out_ready are both high. While out_valid is high and out_ready is low, out_data, out_last and rd_addr hold.
- R8: out_last is high only with byte 12 of the final sector.
- R9: eng_clear is a one-cycle pulse in the cycle after the final byte is accepted. out_valid is low in that same cycle.
- R10: A start pulse that arrives while a readout is in progress is ignored, and the stream length and content do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a readout (idle only) |
| sect_cnt_m1 | input | 3 | Number of sectors minus one, sampled at start |
| rd_addr | output | 5 | Register-file word address, sector*4 + word |
| rd_data | input | 32 | Remainder word at rd_addr, same cycle |
| out_data | output | 8 | Masked ECC byte |
| out_valid | output | 1 | out_data is valid |
| out_ready | input | 1 | Downstream accepts the byte |
| out_last | output | 1 | Final byte of the final sector |
| eng_clear | output | 1 | Pulse that clears the encoder enable bit |

## Verification
The assertions assume that rd_data is a combinational function of rd_addr and that the register file does not change during a readout. With those two assumptions, a stalled output holds its byte. The bench writes the register file only while the block is idle, and returns each word in the same cycle it is addressed. It pulses start both in the idle state and in the middle of a stream, and it varies out_ready freely. It never sets sect_cnt_m1 outside its 3-bit range.

// File: rtl/bch8_pack_pkg.sv
package bch8_pack_pkg;
  localparam int BYTES_PER_SECT = 13;
  localparam int WORDS_PER_SECT = 4;
  localparam int IDX_W = 4;

  // word index feeding byte position idx of a sector
  function automatic logic [1:0] word_of(input logic [IDX_W-1:0] idx);
    if (idx == 0)      return 2'd3;
    else if (idx <= 4) return 2'd2;
    else if (idx <= 8) return 2'd1;
    else               return 2'd0;
  endfunction

  // byte lane (0 = bits 7:0) inside the selected word
  function automatic logic [1:0] lane_of(input logic [IDX_W-1:0] idx);
    logic [IDX_W-1:0] k;
    k = idx - 1'b1;
    if (idx == 0) return 2'd0;
    else          return 2'd3 - k[1:0];
  endfunction

  // constant that turns an erased-sector remainder into all ones
  function automatic logic [7:0] mask_of(input logic [IDX_W-1:0] idx);
    case (idx)
      4'd0:    return 8'hEF;
      4'd1:    return 8'h51;
      4'd2:    return 8'h2E;
      4'd3:    return 8'h09;
      4'd4:    return 8'hED;
      4'd5:    return 8'h93;
      4'd6:    return 8'h9A;
      4'd7:    return 8'hC2;
      4'd8:    return 8'h97;
      4'd9:    return 8'h79;
      4'd10:   return 8'hE5;
      4'd11:   return 8'h24;
      default: return 8'hB5;
    endcase
  endfunction

  function automatic logic [7:0] pick_lane(input logic [31:0] w, input logic [1:0] lane);
    return 8'(w >> {lane, 3'b000});
  endfunction
endpackage

// File: rtl/bch8_pack_seq.sv
module bch8_pack_seq
  import bch8_pack_pkg::*;
#(
  parameter int SECT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SECT_W-1:0] sect_cnt_m1,
  input  logic              ready,
  output logic              valid,
  output logic [SECT_W-1:0] sect,
  output logic [IDX_W-1:0]  idx,
  output logic              last,
  output logic              beat,
  output logic              eng_clear
);
  logic [SECT_W-1:0] last_sect;
  logic              sect_end;
  logic              final_sect;

  assign sect_end   = (idx == IDX_W'(BYTES_PER_SECT - 1));
  assign final_sect = (sect == last_sect);
  assign beat       = valid & ready;
  assign last       = valid & sect_end & final_sect;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid     <= 1'b0;
      sect      <= '0;
      idx       <= '0;
      last_sect <= '0;
      eng_clear <= 1'b0;
    end else begin
      eng_clear <= 1'b0;
      if (!valid) begin
        if (start) begin
          valid     <= 1'b1;
          sect      <= '0;
          idx       <= '0;
          last_sect <= sect_cnt_m1;
        end
      end else if (ready) begin
        if (sect_end) begin
          idx <= '0;
          if (final_sect) begin
            valid     <= 1'b0;
            eng_clear <= 1'b1;
          end else begin
            sect <= sect + 1'b1;
          end
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bch8_pack_lane.sv
module bch8_pack_lane
  import bch8_pack_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  input  logic [31:0]      word,
  output logic [1:0]       word_sel,
  output logic [7:0]       byte_out
);
  assign word_sel = word_of(idx);
  assign byte_out = pick_lane(word, lane_of(idx)) ^ mask_of(idx);
endmodule

// File: rtl/bch8_ecc_packer.sv
module bch8_ecc_packer
  import bch8_pack_pkg::*;
#(
  parameter int MAX_SECT = 8,
  localparam int SECT_W = $clog2(MAX_SECT),
  localparam int ADDR_W = SECT_W + $clog2(WORDS_PER_SECT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SECT_W-1:0] sect_cnt_m1,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [31:0]       rd_data,
  output logic [7:0]        out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_last,
  output logic              eng_clear
);
  logic [SECT_W-1:0] sect;
  logic [IDX_W-1:0]  idx;
  logic [1:0]        word_sel;
  logic              beat;

  bch8_pack_seq #(.SECT_W(SECT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .sect_cnt_m1(sect_cnt_m1),
    .ready(out_ready), .valid(out_valid), .sect(sect), .idx(idx),
    .last(out_last), .beat(beat), .eng_clear(eng_clear)
  );

  bch8_pack_lane u_lane (
    .idx(idx), .word(rd_data), .word_sel(word_sel), .byte_out(out_data)
  );

  assign rd_addr = {sect, word_sel};
endmodule

// File: rtl/bch8_ecc_packer_chk.sv
module bch8_ecc_packer_chk #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [7:0]        out_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_last,
  input logic              eng_clear,
  input logic              beat
);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(rd_addr) && $stable(out_last));

  p_last_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  p_clear_after_final_r9: assert property (@(posedge clk) disable iff (!rst_n)
    beat && out_last |=> eng_clear && !out_valid);

  p_clear_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eng_clear |=> !eng_clear);

  p_first_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> rd_addr == ADDR_W'(3));

  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_last && start |=> out_valid);
endmodule

bind bch8_ecc_packer bch8_ecc_packer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .rd_addr(rd_addr),
  .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
  .out_last(out_last), .eng_clear(eng_clear), .beat(beat)
);

// File: tb/bch8_ecc_packer_tb.sv
module bch8_ecc_packer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] sect_cnt_m1 = '0;
  logic [4:0] rd_addr;
  logic [31:0] rd_data;
  logic [7:0] out_data;
  logic out_valid, out_ready, out_last, eng_clear;

  logic [31:0] rf [32];
  assign rd_data = rf[rd_addr];

  localparam logic [103:0] MASKS = 104'hEF512E09ED939AC29779E524B5;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  int popped = 0;
  int ff_bytes = 0;
  logic [7:0] q_byte[$];
  logic       q_last[$];
  bit clear_exp = 0;
  bit mode_ready_rand = 0;

  always #2 clk = ~clk;

  bch8_ecc_packer u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .sect_cnt_m1(sect_cnt_m1),
    .rd_addr(rd_addr), .rd_data(rd_data), .out_data(out_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_last(out_last),
    .eng_clear(eng_clear)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected stream for sectors 0..nsec-1, built from the register file
  task automatic fill_model(input int nsec);
    for (int s = 0; s < nsec; s++) begin
      logic [7:0] b [13];
      logic [31:0] w3, w2, w1, w0;
      w3 = rf[s*4+3]; w2 = rf[s*4+2]; w1 = rf[s*4+1]; w0 = rf[s*4];
      b[0] = w3[7:0];
      for (int k = 0; k < 4; k++) begin
        b[1+k] = w2[31-8*k -: 8];
        b[5+k] = w1[31-8*k -: 8];
        b[9+k] = w0[31-8*k -: 8];
      end
      for (int k = 0; k < 13; k++) begin
        q_byte.push_back(b[k] ^ MASKS[103-8*k -: 8]);
        q_last.push_back((s == nsec-1) && (k == 12));
      end
    end
  endtask

  // ready pattern, changed only after each posedge
  always @(posedge clk) begin
    #1;
    out_ready <= mode_ready_rand ? ($urandom % 3 != 0) : 1'b1;
  end

  // reference model compared on every clock, sampled at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit was_empty;
      chk(out_valid == (q_byte.size() > 0), "R2 valid", out_valid, q_byte.size() > 0);
      chk(eng_clear == clear_exp, "R9 eng_clear", eng_clear, clear_exp);
      if (out_valid && q_byte.size() > 0) begin
        chk(out_data == q_byte[0], "R3 R4 R6 R7 data", out_data, q_byte[0]);
        chk(out_last == q_last[0], "R8 last", out_last, q_last[0]);
      end
      was_empty = (q_byte.size() == 0);
      clear_exp = 0;
      if (out_valid && out_ready && q_byte.size() > 0) begin
        if (q_byte[0] == 8'hFF) ff_bytes++;
        clear_exp = q_last[0];
        void'(q_byte.pop_front());
        void'(q_last.pop_front());
        popped++;
      end
      if (start && was_empty) fill_model(int'(sect_cnt_m1) + 1);
    end
  end

  task automatic pulse_start(input logic [2:0] cnt);
    @(posedge clk); #1;
    start = 1'b1; sect_cnt_m1 = cnt;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic wait_idle();
    do @(posedge clk); while (q_byte.size() > 0 || out_valid);
    repeat (3) @(posedge clk);
  endtask

  task automatic load_rand();
    for (int i = 0; i < 32; i++) rf[i] = $urandom;
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    out_ready = 1'b1;
    load_rand();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(!out_valid && !out_last && !eng_clear, "R1 reset", {out_valid, out_last, eng_clear}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !eng_clear, "R1 after reset", {out_valid, eng_clear}, 0);

    // R2 single sector, ready always high
    popped = 0;
    pulse_start(3'd0);
    wait_idle();
    chk(popped == 13, "R2 one sector length", popped, 13);

    // R2 R6 all eight sectors with stalls (R7)
    load_rand();
    mode_ready_rand = 1;
    popped = 0;
    pulse_start(3'd7);
    wait_idle();
    chk(popped == 104, "R2 eight sectors length", popped, 104);

    // R5 erased-sector remainders give all-ones bytes
    for (int s = 0; s < 8; s++) begin
      rf[s*4+3] = {24'h5A5A5A, ~MASKS[103:96]};
      rf[s*4+2] = ~MASKS[95:64];
      rf[s*4+1] = ~MASKS[63:32];
      rf[s*4+0] = ~MASKS[31:0];
    end
    popped = 0; ff_bytes = 0;
    pulse_start(3'd3);
    wait_idle();
    chk(ff_bytes == 52, "R5 all 0xFF", ff_bytes, 52);

    // R10 start pulses during a readout are ignored
    load_rand();
    popped = 0;
    pulse_start(3'd2);
    repeat (5) @(posedge clk);
    pulse_start(3'd7);
    repeat (4) @(posedge clk);
    pulse_start(3'd5);
    wait_idle();
    chk(popped == 39, "R10 stream length unchanged", popped, 39);

    // R2 middle count with ready always high
    mode_ready_rand = 0;
    load_rand();
    popped = 0;
    pulse_start(3'd4);
    wait_idle();
    chk(popped == 65, "R2 five sectors length", popped, 65);

    repeat (4) @(posedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule